// File: doc/BRIEF.md
# Pulse-Position Downlink Frame Decoder

This block turns the reader-to-tag command stream of a 13.56 MHz contactless link into bytes. It runs on a clock at carrier rate. Its only data input is the active-high pause flag from an external amplitude demodulator. The flag is resynchronised and cleaned of short glitches. The decoder then hunts for a start-of-frame pattern, and that pattern fixes the coding mode for the rest of the frame. After that, every value is carried by the time slot in which a pause begins.

A slot lasts `2**SLOT_LOG2` clock cycles (256 carrier cycles by default). A data pause must begin in the second half of its slot. In the one-of-256 mode, one pause across 256 consecutive slots gives one byte. In the one-of-4 mode, one pause across 4 slots gives two bits, and four such groups form a byte. A pause that begins in the first half of a slot ends the frame. A misplaced or missing pause reports an error, and the decoder goes back to hunting for the next frame.

Top module: `ppm_frame_dec`

## Requirements
- R1: While reset is held, and in the cycle after it, `byte_valid`, `frame_start`, `frame_end` and `frame_err` are all 0.
- R2: For the first `PWRUP_CYC` cycles after reset, pauses are ignored. A complete start pattern sent in that window produces no `frame_start` and no `frame_err`.
- R3: A high level on `pause_i` shorter than `MIN_W` consecutive cycles is not seen as a pause. A 2-cycle glitch placed between the two start pauses leaves the frame valid.
- R4: The start pattern is two pauses. Let H be half a slot. A gap of 4H ± H/2 between their leading edges selects one-of-256, reported as `frame_mode`=1. A gap of 6H ± H/2 selects one-of-4, reported as `frame_mode`=0. In either case `frame_start` pulses. Any other second-pause gap pulses `frame_err` instead. Slot 0 of the data starts one slot after the second start pause.
- R5: In one-of-256 mode, a pause beginning in the second half of slot n (0..255) of a byte period yields `byte_data`=n.
- R6: In one-of-4 mode, a pause in slot k (0..3) of a 4-slot group yields the bit pair k. The first group of a byte supplies bits [1:0] and the fourth supplies bits [7:6].
- R7: A second data pause in the same byte period (one-of-256) or pair period (one-of-4) pulses `frame_err`, yields no byte and ends the frame.
- R8: A byte or pair period that ends with no data pause pulses `frame_err` and ends the frame.
- R9: A pause beginning in the first half of slot 0 of a fresh byte pulses `frame_end`. This includes a frame with no bytes. A first-half pause anywhere else pulses `frame_err` and not `frame_end`.
- R10: Once a frame has ended or failed, the next start pattern is accepted at once, within the following slot.
- R11: `byte_valid`, `frame_end` and `frame_err` are single-cycle pulses that occur only inside a frame. `frame_end` never coincides with `byte_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pause_i | input | 1 | Pause flag from the demodulator, asynchronous, active high |
| byte_valid | output | 1 | Pulse: `byte_data` holds a decoded byte |
| byte_data | output | 8 | Decoded byte |
| frame_start | output | 1 | Pulse: a valid start pattern was recognised |
| frame_mode | output | 1 | Coding mode of the current frame: 0 = one-of-4, 1 = one-of-256 |
| frame_end | output | 1 | Pulse: frame closed on a byte boundary |
| frame_err | output | 1 | Pulse: coding violation or bad start pattern |

## Verification
Every decision depends on the slot timer being in phase with the start pattern. If the slot or cycle count is off, the fault shows at the ports within one symbol period. It appears either as a wrong byte value, typically offset by one slot, or as a data pause taken for an end-of-frame, which raises `frame_err`. If the pair counter or the pending-pause flag is wrong, a valid end-of-frame turns into an error, or a double pause goes unreported. Both show in the same frame. Power-up hold and glitch filtering are checked through the absence or presence of `frame_start`.

// File: rtl/ppm_pkg.sv
// Shared types for the pulse-position downlink decoder.
package ppm_pkg;
    // Coding mode picked by the start pattern; the value is the frame_mode output.
    typedef enum logic {
        CODE_1OF4   = 1'b0,
        CODE_1OF256 = 1'b1
    } code_mode_t;

    // Start-pattern hunter state.
    typedef enum logic {
        SOF_HUNT,
        SOF_GAP
    } sof_state_t;

    // Symbol decoder phase.
    typedef enum logic [1:0] {
        SYM_IDLE,
        SYM_LEAD,
        SYM_DATA
    } sym_phase_t;
endpackage

// File: rtl/ppm_pause_cond.sv
// Pause conditioner: two-flop synchroniser, then a filter that changes its
// output only after MIN_W consecutive cycles at the new level. Gives a
// single-cycle pulse on each accepted pause leading edge.
// Assumes MIN_W >= 2. The latency is fixed, so relative timing is preserved.
module ppm_pause_cond #(
    parameter int MIN_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pause_i,
    output logic rise_o
);
    localparam int CW = $clog2(MIN_W);

    logic          sync0, sync1;
    logic          filt, filt_q;
    logic [CW-1:0] cnt;

    // Bring the asynchronous pause flag into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync0 <= 1'b0;
            sync1 <= 1'b0;
        end else begin
            sync0 <= pause_i;
            sync1 <= sync0;
        end
    end

    // Accept a level change only after it has persisted for MIN_W cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt   <= 1'b0;
            filt_q <= 1'b0;
            cnt    <= '0;
        end else begin
            filt_q <= filt;
            if (sync1 != filt) begin
                if (cnt == CW'(MIN_W - 1)) begin
                    filt <= sync1;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt <= '0;
            end
        end
    end

    assign rise_o = filt & ~filt_q;
endmodule

// File: rtl/ppm_sof_det.sv
// Start-pattern hunter: measures the gap between two pause leading edges and
// classifies it as a one-of-4 start, a one-of-256 start, or a violation.
// Assumes en is low while a frame is being decoded; a low en clears the hunt.
module ppm_sof_det
    import ppm_pkg::*;
#(
    parameter int SLOT_LOG2 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       rise,
    output logic       sof_ok,
    output logic       sof_err,
    output code_mode_t mode_o
);
    localparam int H      = 1 << (SLOT_LOG2 - 1);
    localparam int Q      = H / 2;
    localparam int GW     = SLOT_LOG2 + 3;
    localparam int G4_LO  = 6 * H - Q;
    localparam int G4_HI  = 6 * H + Q;
    localparam int G256_LO = 4 * H - Q;
    localparam int G256_HI = 4 * H + Q;
    localparam int G_MAX  = 7 * H;

    sof_state_t    state;
    logic [GW-1:0] gap;
    logic          in4, in256;

    assign in4   = (int'(gap) >= G4_LO)   && (int'(gap) < G4_HI);
    assign in256 = (int'(gap) >= G256_LO) && (int'(gap) < G256_HI);

    // Track the first pause, time the gap, judge at the second pause.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SOF_HUNT;
            gap     <= '0;
            sof_ok  <= 1'b0;
            sof_err <= 1'b0;
            mode_o  <= CODE_1OF4;
        end else if (!en) begin
            state   <= SOF_HUNT;
            gap     <= '0;
            sof_ok  <= 1'b0;
            sof_err <= 1'b0;
        end else begin
            sof_ok  <= 1'b0;
            sof_err <= 1'b0;
            case (state)
                SOF_HUNT: begin
                    if (rise) begin
                        state <= SOF_GAP;
                        gap   <= GW'(1);
                    end
                end
                SOF_GAP: begin
                    if (rise) begin
                        state <= SOF_HUNT;
                        if (in4) begin
                            sof_ok <= 1'b1;
                            mode_o <= CODE_1OF4;
                        end else if (in256) begin
                            sof_ok <= 1'b1;
                            mode_o <= CODE_1OF256;
                        end else begin
                            sof_err <= 1'b1;
                        end
                    end else if (int'(gap) == G_MAX) begin
                        state <= SOF_HUNT;
                    end else begin
                        gap <= gap + 1'b1;
                    end
                end
                default: state <= SOF_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/ppm_sym_dec.sv
// Symbol decoder: keeps slot timing from the start pattern, turns pause slot
// positions into bytes, recognises end of frame and flags coding violations.
// Assumes start is a single-cycle pulse one cycle after the second start
// pause edge, and that SLOT_LOG2 >= 3.
module ppm_sym_dec
    import ppm_pkg::*;
#(
    parameter int SLOT_LOG2 = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  code_mode_t mode,
    input  logic       rise,
    output logic       busy,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       frame_end,
    output logic       viol
);
    localparam int SW        = SLOT_LOG2;
    localparam int START_OFS = 2;

    sym_phase_t    phase;
    code_mode_t    mode_q;
    logic [SW-1:0] cyc;
    logic [7:0]    sidx;
    logic [7:0]    val;
    logic [7:0]    shreg;
    logic [1:0]    pair;
    logic          got;

    logic       slot_end, last_slot, early_hit, data_hit, got_eff;
    logic [7:0] val_eff, sh_ins;

    // Per-cycle slot decisions.
    always_comb begin
        slot_end  = &cyc;
        last_slot = (mode_q == CODE_1OF4) ? (sidx == 8'd3) : (sidx == 8'd255);
        early_hit = rise && !cyc[SW-1];
        data_hit  = rise &&  cyc[SW-1];
        got_eff   = got | data_hit;
        val_eff   = data_hit ? sidx : val;
        sh_ins    = shreg;
        sh_ins[2*pair +: 2] = val_eff[1:0];
    end

    // Slot timing, symbol capture, byte assembly and frame termination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= SYM_IDLE;
            mode_q     <= CODE_1OF4;
            cyc        <= '0;
            sidx       <= '0;
            val        <= '0;
            shreg      <= '0;
            pair       <= '0;
            got        <= 1'b0;
            byte_valid <= 1'b0;
            byte_data  <= '0;
            frame_end  <= 1'b0;
            viol       <= 1'b0;
        end else begin
            byte_valid <= 1'b0;
            frame_end  <= 1'b0;
            viol       <= 1'b0;
            case (phase)
                SYM_IDLE: begin
                    if (start) begin
                        phase  <= SYM_LEAD;
                        mode_q <= mode;
                        cyc    <= SW'(START_OFS);
                        sidx   <= '0;
                        pair   <= '0;
                        got    <= 1'b0;
                    end
                end
                SYM_LEAD: begin
                    if (rise) begin
                        viol  <= 1'b1;
                        phase <= SYM_IDLE;
                    end else begin
                        cyc <= cyc + 1'b1;
                        if (slot_end) phase <= SYM_DATA;
                    end
                end
                SYM_DATA: begin
                    if (early_hit) begin
                        phase <= SYM_IDLE;
                        if (sidx == 8'd0 && !got && pair == 2'd0) frame_end <= 1'b1;
                        else                                      viol      <= 1'b1;
                    end else if (data_hit && got) begin
                        phase <= SYM_IDLE;
                        viol  <= 1'b1;
                    end else begin
                        cyc <= cyc + 1'b1;
                        if (data_hit) begin
                            got <= 1'b1;
                            val <= sidx;
                        end
                        if (slot_end) begin
                            if (!last_slot) begin
                                sidx <= sidx + 1'b1;
                            end else if (!got_eff) begin
                                phase <= SYM_IDLE;
                                viol  <= 1'b1;
                            end else begin
                                sidx <= '0;
                                got  <= 1'b0;
                                if (mode_q == CODE_1OF256) begin
                                    byte_valid <= 1'b1;
                                    byte_data  <= val_eff;
                                end else begin
                                    shreg <= sh_ins;
                                    pair  <= pair + 1'b1;
                                    if (pair == 2'd3) begin
                                        byte_valid <= 1'b1;
                                        byte_data  <= sh_ins;
                                    end
                                end
                            end
                        end
                    end
                end
                default: phase <= SYM_IDLE;
            endcase
        end
    end

    assign busy = (phase != SYM_IDLE);
endmodule

// File: rtl/ppm_frame_dec.sv
// Pulse-position downlink frame decoder top: power-up hold, pause
// conditioning, start-pattern hunt and symbol decoding.
// Assumes clk runs at carrier rate and pause_i is high during a pause.
module ppm_frame_dec
    import ppm_pkg::*;
#(
    parameter int SLOT_LOG2 = 8,
    parameter int MIN_W     = 3,
    parameter int PWRUP_CYC = 1356
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pause_i,
    output logic       byte_valid,
    output logic [7:0] byte_data,
    output logic       frame_start,
    output logic       frame_mode,
    output logic       frame_end,
    output logic       frame_err
);
    localparam int PCW = $clog2(PWRUP_CYC + 1);

    logic [PCW-1:0] pw_cnt;
    logic           powered, rise, busy, sof_ok, sof_err, sym_viol;
    code_mode_t     sof_mode;

    // Hold the hunt off until the power-up interval has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n)        pw_cnt <= '0;
        else if (!powered) pw_cnt <= pw_cnt + 1'b1;
    end
    assign powered = (pw_cnt == PCW'(PWRUP_CYC));

    ppm_pause_cond #(.MIN_W(MIN_W)) u_cond (
        .clk    (clk),
        .rst_n  (rst_n),
        .pause_i(pause_i),
        .rise_o (rise)
    );

    ppm_sof_det #(.SLOT_LOG2(SLOT_LOG2)) u_sof (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (powered && !busy),
        .rise   (rise),
        .sof_ok (sof_ok),
        .sof_err(sof_err),
        .mode_o (sof_mode)
    );

    ppm_sym_dec #(.SLOT_LOG2(SLOT_LOG2)) u_sym (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (sof_ok),
        .mode      (sof_mode),
        .rise      (rise),
        .busy      (busy),
        .byte_valid(byte_valid),
        .byte_data (byte_data),
        .frame_end (frame_end),
        .viol      (sym_viol)
    );

    assign frame_start = sof_ok;
    assign frame_mode  = sof_mode;
    assign frame_err   = sof_err | sym_viol;
endmodule

// File: rtl/ppm_frame_dec_chk.sv
// Checker for ppm_frame_dec: pulse discipline, power-up hold and frame
// bracketing seen at the ports. Bound to every instance of the top.
module ppm_frame_dec_chk #(
    parameter int PWRUP_CYC = 1356
) (
    input logic clk,
    input logic rst_n,
    input logic byte_valid,
    input logic frame_start,
    input logic frame_end,
    input logic frame_err
);
    localparam int PCW = $clog2(PWRUP_CYC + 1);

    logic [PCW-1:0] age;
    logic           in_frame;

    // Count cycles since reset, saturating at the power-up interval.
    always_ff @(posedge clk) begin
        if (!rst_n)                         age <= '0;
        else if (age != PCW'(PWRUP_CYC))    age <= age + 1'b1;
    end

    // Track whether a frame has been opened and not yet closed.
    always_ff @(posedge clk) begin
        if (!rst_n)                      in_frame <= 1'b0;
        else if (frame_end || frame_err) in_frame <= 1'b0;
        else if (frame_start)            in_frame <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !byte_valid && !frame_start && !frame_end && !frame_err);

    // R2
    pwrup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age != PCW'(PWRUP_CYC)) |-> !frame_start);

    // R9
    end_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> in_frame);

    // R11
    byte_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |-> in_frame);

    // R11
    end_not_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !byte_valid);

    // R4
    start_not_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> !frame_err);
endmodule

bind ppm_frame_dec ppm_frame_dec_chk #(.PWRUP_CYC(PWRUP_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .frame_start(frame_start),
    .frame_end  (frame_end),
    .frame_err  (frame_err)
);

// File: tb/sim_ppm_frame_dec.sv
`timescale 1ns/1ps
module sim_ppm_frame_dec;
    localparam int SLOT_LOG2 = 4;
    localparam int SLOT      = 1 << SLOT_LOG2;
    localparam int HALF      = SLOT / 2;
    localparam int MIN_W     = 3;
    localparam int PWRUP     = 80;
    localparam int PW        = HALF / 2;

    // {mode, byte count, byte0, byte1, byte2}; mode 0 = one-of-4, 1 = one-of-256
    localparam int NVEC = 6;
    localparam logic [39:0] VEC [0:NVEC-1] = '{
        {8'h00, 8'd3, 8'hE1, 8'h00, 8'hFF},
        {8'h01, 8'd1, 8'h00, 8'h00, 8'h00},
        {8'h01, 8'd2, 8'hFF, 8'hE1, 8'h00},
        {8'h00, 8'd2, 8'h5A, 8'hA5, 8'h00},
        {8'h00, 8'd0, 8'h00, 8'h00, 8'h00},
        {8'h01, 8'd3, 8'h80, 8'h01, 8'h7F}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pause_i = 1'b0;
    logic       byte_valid, frame_start, frame_mode, frame_end, frame_err;
    logic [7:0] byte_data;

    int n_chk = 0, n_err = 0;
    int n_rx = 0, n_fs = 0, n_fe = 0, n_fer = 0, n_ovl = 0;
    logic [7:0] rx [0:255];
    logic last_mode = 1'b0;
    int tcur = 0, base = 0;
    int s_rx, s_fs, s_fe, s_fer;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ppm_frame_dec #(.SLOT_LOG2(SLOT_LOG2), .MIN_W(MIN_W), .PWRUP_CYC(PWRUP)) u0 (
        .clk(clk), .rst_n(rst_n), .pause_i(pause_i),
        .byte_valid(byte_valid), .byte_data(byte_data),
        .frame_start(frame_start), .frame_mode(frame_mode),
        .frame_end(frame_end), .frame_err(frame_err)
    );

    // Port monitor, sampled between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid) begin rx[n_rx[7:0]] = byte_data; n_rx++; end
            if (frame_start) begin n_fs++; last_mode = frame_mode; end
            if (frame_end) n_fe++;
            if (frame_err) n_fer++;
            if (byte_valid && frame_end) n_ovl++;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic snap();
        s_rx = n_rx; s_fs = n_fs; s_fe = n_fe; s_fer = n_fer;
    endtask

    task automatic pulse_at(input int t, input int w);
        while (tcur < t) begin @(negedge clk); tcur++; end
        pause_i = 1'b1;
        repeat (w) @(negedge clk);
        pause_i = 1'b0;
        tcur += w;
    endtask

    task automatic send_sof(input logic m);
        int gap;
        gap  = m ? 4 * HALF : 6 * HALF;
        tcur = 0;
        pulse_at(0, PW);
        pulse_at(gap, PW);
        base = gap + SLOT;
    endtask

    task automatic send_pair(input int v);
        pulse_at(base + v * SLOT + HALF, PW);
        base += 4 * SLOT;
    endtask

    task automatic send_byte(input logic m, input logic [7:0] b);
        if (m) begin
            pulse_at(base + int'(b) * SLOT + HALF, PW);
            base += 256 * SLOT;
        end else begin
            for (int i = 0; i < 4; i++) send_pair(int'((b >> (2 * i)) & 8'h3));
        end
    endtask

    task automatic send_eof();
        pulse_at(base + 2, PW);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic       m;
        int         nb;
        logic [7:0] b [0:2];
        string      tg;

        repeat (3) @(negedge clk);
        // R1: outputs quiet under reset
        chk("R1 byte_valid", int'(byte_valid), 0);
        chk("R1 frame_start", int'(frame_start), 0);
        chk("R1 frame_err", int'(frame_err), 0);
        rst_n = 1'b1;

        // R2: a full start pattern during the power-up hold is ignored
        snap();
        send_sof(1'b0);
        repeat (PWRUP) @(negedge clk);
        chk("R2 no frame_start", n_fs - s_fs, 0);
        chk("R2 no frame_err", n_fer - s_fer, 0);

        // Table walk: R4 mode, R5/R6 bytes, R9 end, R10 back-to-back acceptance
        for (int v = 0; v < NVEC; v++) begin
            m    = VEC[v][32];
            nb   = int'(VEC[v][31:24]);
            b[0] = VEC[v][23:16];
            b[1] = VEC[v][15:8];
            b[2] = VEC[v][7:0];
            tg   = m ? "R5" : "R6";
            snap();
            send_sof(m);
            for (int i = 0; i < nb; i++) send_byte(m, b[i]);
            send_eof();
            repeat (2 * SLOT) @(negedge clk);
            chk("R4 R10 frame_start", n_fs - s_fs, 1);
            chk("R4 mode", int'(last_mode), int'(m));
            chk({tg, " byte count"}, n_rx - s_rx, nb);
            for (int i = 0; i < nb; i++) chk({tg, " byte value"}, int'(rx[8'(s_rx + i)]), int'(b[i]));
            chk("R9 frame_end", n_fe - s_fe, 1);
            chk("R9 no err", n_fer - s_fer, 0);
        end

        // R3: glitch between the start pauses is filtered
        snap();
        tcur = 0;
        pulse_at(0, PW);
        pulse_at(20, MIN_W - 1);
        pulse_at(6 * HALF, PW);
        base = 6 * HALF + SLOT;
        send_eof();
        repeat (2 * SLOT) @(negedge clk);
        chk("R3 frame_start", n_fs - s_fs, 1);
        chk("R3 frame_end", n_fe - s_fe, 1);
        chk("R3 no err", n_fer - s_fer, 0);

        // R4: gap of 5H is not a start pattern
        snap();
        tcur = 0;
        pulse_at(0, PW);
        pulse_at(5 * HALF, PW);
        repeat (8 * SLOT) @(negedge clk);
        chk("R4 bad gap err", n_fer - s_fer, 1);
        chk("R4 bad gap no start", n_fs - s_fs, 0);

        // R7: two pauses in one pair period
        snap();
        send_sof(1'b0);
        pulse_at(base + HALF, PW);
        pulse_at(base + 2 * SLOT + HALF, PW);
        repeat (8 * SLOT) @(negedge clk);
        chk("R7 err", n_fer - s_fer, 1);
        chk("R7 no byte", n_rx - s_rx, 0);
        chk("R7 no end", n_fe - s_fe, 0);

        // R8: pair period with no pause
        snap();
        send_sof(1'b0);
        repeat (6 * SLOT) @(negedge clk);
        chk("R8 err", n_fer - s_fer, 1);
        chk("R8 no end", n_fe - s_fe, 0);

        // R9: end pause after two pairs (mid-byte) is a violation
        snap();
        send_sof(1'b0);
        send_pair(1);
        send_pair(2);
        send_eof();
        repeat (8 * SLOT) @(negedge clk);
        chk("R9 mid-byte err", n_fer - s_fer, 1);
        chk("R9 mid-byte no end", n_fe - s_fe, 0);
        chk("R9 mid-byte no byte", n_rx - s_rx, 0);

        // R10: a frame right after a violation decodes
        snap();
        send_sof(1'b1);
        send_byte(1'b1, 8'h3C);
        send_eof();
        repeat (2 * SLOT) @(negedge clk);
        chk("R10 start", n_fs - s_fs, 1);
        chk("R10 byte", int'(rx[8'(s_rx)]), 8'h3C);
        chk("R10 end", n_fe - s_fe, 1);

        // R11: frame_end never coincided with byte_valid
        chk("R11 overlap", n_ovl, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule